// File: doc/BRIEF.md
# Seven-to-one display lane serializer

This block turns one parallel display word per pixel clock into three serial data lanes and one forwarded clock lane. Each pixel period is divided into seven bit periods. The word carries eighteen colour bits, six each for red, green and blue, and three timing bits: line sync, frame sync and data-enable. All lane logic runs on a bit clock at seven times the pixel rate, which is supplied from outside. The pixel clock is oversampled in that domain. A word is captured at the first bit-clock edge that sees the pixel clock low after it was high.

Two conditions force the lanes low. A low `power_on` input puts all four lanes in a quiet low state. A watchdog counts bit-clock edges since the last pixel-clock transition, declares the pixel clock lost once the gap grows too long, and then holds every lane low, including the clock lane. When either condition ends, the outputs stay low until a fresh word has been captured under clean conditions. Serialization then resumes with that word.

Top module: `pxlink_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first word is captured, all three data lanes and the clock lane are low.
- R2: A word is captured at the first bit-clock rising edge that sees `pix_clk` low when the previous bit-clock edge saw it high. Input values at any other edge have no effect on the lanes.
- R3: The captured word is formed as {data_en, frame_sync, line_sync, blue[5:0], green[5:0], red[5:0]}, with red[0] at bit 0. Data lane k carries word bits 7k+6 down to 7k, highest first, so the lowest-numbered bit goes last. Slot 0 appears in the bit period that starts at the capture edge.
- R4: In each pixel period, the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6. It is aligned to the same capture edge as the data lanes.
- R5: If no new capture happens, each lane keeps repeating its last seven-bit group, one bit per bit period.
- R6: After 17 consecutive bit-clock edges that see no change on `pix_clk`, the clock is considered lost. From the 17th such edge on, all four lanes are low.
- R7: The lost condition clears at the first bit-clock edge that sees `pix_clk` change. The lanes stay low until a capture edge arrives while the lost condition is already clear.
- R8: While `power_on` is low, all four lanes are low in that same bit period.
- R9: After `power_on` returns high, the lanes stay low until a capture edge that sees `power_on` high. That word is then serialized from slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, oversampled on bit_clk |
| power_on | input | 1 | High to operate, low to force all lanes low |
| red | input | 6 | Red colour bits |
| green | input | 6 | Green colour bits |
| blue | input | 6 | Blue colour bits |
| line_sync | input | 1 | Line synchronisation bit |
| frame_sync | input | 1 | Frame synchronisation bit |
| data_en | input | 1 | Data-enable bit |
| lane_data | output | 3 | Serial data lanes, bit k is lane k |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
Slot 0 of a captured word is on the lanes right after the capture edge, with no extra register stage. The bench therefore compares every lane at the falling bit-clock edge that follows each rising edge. A running slot index is reset at each capture the bench predicts from its own view of `pix_clk`. The lost condition is due exactly 17 stalled edges after the last transition, and the bench counts that gap itself. Power gating takes effect in the same bit period, while re-arming waits for the next predicted capture. The bench checks every sample of the sweeps against a requirement-level model, so it tests the exact cycle and not a window.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } ser_order_e;

   localparam int unsigned DEF_COLOR_W    = 6;
   localparam int unsigned DEF_LANES      = 3;
   localparam int unsigned DEF_LANE_BITS  = 7;
   localparam int unsigned DEF_LOSS_LIMIT = 16;

   // counter width able to hold the value lim
   function automatic int unsigned cnt_width(int unsigned lim);
      int unsigned w;
      w = $clog2(lim + 1);
      if (w < 1) w = 1;
      return w;
   endfunction

endpackage

// File: rtl/pxl_clk_watch.sv
module pxl_clk_watch #(
   parameter int unsigned LOSS_LIMIT = pxl_pkg::DEF_LOSS_LIMIT
) (
   input  logic bit_clk,
   input  logic rst_n,
   input  logic pix_clk,
   output logic fall_stb,
   output logic lost
);
   localparam int unsigned CW = pxl_pkg::cnt_width(LOSS_LIMIT);

   if (LOSS_LIMIT < 2) begin : g_bad_limit
      $error("pxl_clk_watch: LOSS_LIMIT must be at least 2");
   end

   logic          pix_q;
   logic          edge_seen;
   logic [CW-1:0] gap_q;

   assign edge_seen = pix_q ^ pix_clk;
   assign fall_stb  = pix_q & ~pix_clk;

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= 1'b0;
         gap_q <= '0;
         lost  <= 1'b0;
      end else begin
         pix_q <= pix_clk;
         if (edge_seen) begin
            gap_q <= '0;
            lost  <= 1'b0;
         end else if (gap_q == CW'(LOSS_LIMIT)) begin
            lost  <= 1'b1;
         end else begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pxl_lane_shift.sv
module pxl_lane_shift #(
   parameter int unsigned         W     = pxl_pkg::DEF_LANE_BITS,
   parameter pxl_pkg::ser_order_e ORDER = pxl_pkg::ORDER_MSB_FIRST
) (
   input  logic         bit_clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         sout
);
   if (W < 2) begin : g_bad_width
      $error("pxl_lane_shift: W must be at least 2");
   end

   logic [W-1:0] sh_q;

   if (ORDER == pxl_pkg::ORDER_MSB_FIRST) begin : g_msb
      always_ff @(posedge bit_clk or negedge rst_n) begin
         if (!rst_n)    sh_q <= '0;
         else if (load) sh_q <= din;
         else           sh_q <= {sh_q[W-2:0], sh_q[W-1]};
      end
      assign sout = sh_q[W-1];
   end else begin : g_lsb
      always_ff @(posedge bit_clk or negedge rst_n) begin
         if (!rst_n)    sh_q <= '0;
         else if (load) sh_q <= din;
         else           sh_q <= {sh_q[0], sh_q[W-1:1]};
      end
      assign sout = sh_q[0];
   end

endmodule

// File: rtl/pxl_out_gate.sv
module pxl_out_gate #(
   parameter int unsigned N = pxl_pkg::DEF_LANES + 1
) (
   input  logic         bit_clk,
   input  logic         rst_n,
   input  logic         power_on,
   input  logic         lost,
   input  logic         fall_stb,
   input  logic [N-1:0] raw,
   output logic [N-1:0] gated,
   output logic         primed
);
   logic enable;

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)                 primed <= 1'b0;
      else if (!power_on || lost) primed <= 1'b0;
      else if (fall_stb)          primed <= 1'b1;
   end

   assign enable = primed & power_on & ~lost;
   assign gated  = raw & {N{enable}};

endmodule

// File: rtl/pxlink_serializer.sv
module pxlink_serializer #(
   parameter int unsigned           COLOR_W     = pxl_pkg::DEF_COLOR_W,
   parameter int unsigned           LANES       = pxl_pkg::DEF_LANES,
   parameter int unsigned           LANE_BITS   = pxl_pkg::DEF_LANE_BITS,
   parameter int unsigned           LOSS_LIMIT  = pxl_pkg::DEF_LOSS_LIMIT,
   parameter logic [LANE_BITS-1:0]  CLK_PATTERN = 7'b1100011,
   parameter pxl_pkg::ser_order_e   ORDER       = pxl_pkg::ORDER_MSB_FIRST
) (
   input  logic               bit_clk,
   input  logic               rst_n,
   input  logic               pix_clk,
   input  logic               power_on,
   input  logic [COLOR_W-1:0] red,
   input  logic [COLOR_W-1:0] green,
   input  logic [COLOR_W-1:0] blue,
   input  logic               line_sync,
   input  logic               frame_sync,
   input  logic               data_en,
   output logic [LANES-1:0]   lane_data,
   output logic               lane_clk
);
   localparam int unsigned WORD_W = 3 * COLOR_W + 3;
   localparam int unsigned ALL_W  = LANES + 1;

   if (WORD_W != LANES * LANE_BITS) begin : g_bad_fit
      $error("pxlink_serializer: word width must equal LANES*LANE_BITS");
   end

   logic [WORD_W-1:0] word;
   logic [ALL_W-1:0]  raw;
   logic [ALL_W-1:0]  gated;
   logic              cap_stb;
   logic              lost;
   logic              primed;

   assign word = {data_en, frame_sync, line_sync, blue, green, red};

   pxl_clk_watch #(.LOSS_LIMIT(LOSS_LIMIT)) u_watch (
      .bit_clk  (bit_clk),
      .rst_n    (rst_n),
      .pix_clk  (pix_clk),
      .fall_stb (cap_stb),
      .lost     (lost)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pxl_lane_shift #(.W(LANE_BITS), .ORDER(ORDER)) u_shift (
         .bit_clk (bit_clk),
         .rst_n   (rst_n),
         .load    (cap_stb),
         .din     (word[k*LANE_BITS +: LANE_BITS]),
         .sout    (raw[k])
      );
   end

   pxl_lane_shift #(.W(LANE_BITS), .ORDER(ORDER)) u_clk_lane (
      .bit_clk (bit_clk),
      .rst_n   (rst_n),
      .load    (cap_stb),
      .din     (CLK_PATTERN),
      .sout    (raw[LANES])
   );

   pxl_out_gate #(.N(ALL_W)) u_gate (
      .bit_clk  (bit_clk),
      .rst_n    (rst_n),
      .power_on (power_on),
      .lost     (lost),
      .fall_stb (cap_stb),
      .raw      (raw),
      .gated    (gated),
      .primed   (primed)
   );

   assign lane_data = gated[LANES-1:0];
   assign lane_clk  = gated[LANES];

endmodule

// File: rtl/pxlink_serializer_chk.sv
module pxlink_serializer_chk #(
   parameter int unsigned LANES         = pxl_pkg::DEF_LANES,
   parameter int unsigned LOSS_LIMIT    = pxl_pkg::DEF_LOSS_LIMIT,
   parameter logic        FIRST_CLK_BIT = 1'b1
) (
   input logic             bit_clk,
   input logic             rst_n,
   input logic             pix_clk,
   input logic             power_on,
   input logic [LANES-1:0] lane_data,
   input logic             lane_clk,
   input logic             cap_stb,
   input logic             lost,
   input logic             primed
);
   localparam int unsigned GW = pxl_pkg::cnt_width(LOSS_LIMIT + 1);

   logic          pix_prev;
   logic [GW-1:0] gap;

   // independent stall counter, saturating one above the limit
   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_prev <= 1'b0;
         gap      <= '0;
      end else begin
         pix_prev <= pix_clk;
         if (pix_clk != pix_prev)             gap <= '0;
         else if (gap != GW'(LOSS_LIMIT + 1)) gap <= gap + 1'b1;
      end
   end

   p_quiet_unprimed_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !primed |-> (lane_data == '0 && !lane_clk));

   p_clk_lead_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (cap_stb && power_on && !lost) |=> (lane_clk == FIRST_CLK_BIT || !power_on || lost));

   p_lost_gap_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (gap > GW'(LOSS_LIMIT)) |-> (lost && lane_data == '0 && !lane_clk));

   p_edge_clears_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (pix_clk != pix_prev) |=> !lost);

   p_lost_unprimes_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
      lost |=> !primed);

   p_power_low_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !power_on |-> (lane_data == '0 && !lane_clk));

   p_power_unprimes_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !power_on |=> !primed);

   p_prime_on_capture_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (cap_stb && power_on && !lost) |=> primed);

endmodule

bind pxlink_serializer pxlink_serializer_chk #(
   .LANES      (LANES),
   .LOSS_LIMIT (LOSS_LIMIT)
) u_chk (
   .bit_clk   (bit_clk),
   .rst_n     (rst_n),
   .pix_clk   (pix_clk),
   .power_on  (power_on),
   .lane_data (lane_data),
   .lane_clk  (lane_clk),
   .cap_stb   (cap_stb),
   .lost      (lost),
   .primed    (primed)
);

// File: tb/pxlink_serializer_bench.sv
`timescale 1ns/1ps
module pxlink_serializer_bench;

   logic       bit_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_clk = 1'b1;
   logic       power_on = 1'b1;
   logic [5:0] red = '0, green = '0, blue = '0;
   logic       line_sync = 1'b0, frame_sync = 1'b0, data_en = 1'b0;
   logic [2:0] lane_data;
   logic       lane_clk;

   always #2.5 bit_clk = ~bit_clk;

   pxlink_serializer u_pxlink_serializer (
      .bit_clk    (bit_clk),
      .rst_n      (rst_n),
      .pix_clk    (pix_clk),
      .power_on   (power_on),
      .red        (red),
      .green      (green),
      .blue       (blue),
      .line_sync  (line_sync),
      .frame_sync (frame_sync),
      .data_en    (data_en),
      .lane_data  (lane_data),
      .lane_clk   (lane_clk)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // requirement-level model state
   logic        pc_prev = 1'b0;
   int          gap = 0;
   bit          lost_m = 0;
   bit          primed_m = 0;
   logic [20:0] ew = '0;
   int          slot = 0;
   int          ph = 0;
   bit          stall = 0;
   logic [31:0] seed = 32'h1234_5678;
   localparam logic [6:0] CLK_PAT = 7'b1100011;

   function automatic logic [20:0] cur_word();
      return {data_en, frame_sync, line_sync, blue, green, red};
   endfunction

   task automatic put(input logic [20:0] w);
      {data_en, frame_sync, line_sync, blue, green, red} = w;
   endtask

   function automatic logic [20:0] next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[30:10];
   endfunction

   task automatic report(input string tag, input logic [2:0] ed, input logic ec);
      checks++;
      if (lane_data !== ed || lane_clk !== ec) begin
         errors++;
         $display("FAIL %s t=%0t lane_data=%b exp=%b lane_clk=%b exp=%b",
                  tag, $time, lane_data, ed, lane_clk, ec);
      end
   endtask

   // sample after the rising edge, then advance the pixel clock
   task automatic tick(input string tag);
      bit          edge_s, cap, old_lost, on;
      logic [2:0]  ed;
      logic        ec;
      @(negedge bit_clk);
      if (!rst_n) begin
         pc_prev  = 1'b0;
         gap      = 0;
         lost_m   = 0;
         primed_m = 0;
         report("R1 reset", 3'b000, 1'b0);
      end else begin
         edge_s   = (pc_prev != pix_clk);
         cap      = pc_prev && !pix_clk;
         old_lost = lost_m;
         if (edge_s) begin gap = 0; lost_m = 0; end
         else begin gap++; if (gap > 16) lost_m = 1; end
         if (!power_on || old_lost) primed_m = 0;
         else if (cap)              primed_m = 1;
         if (cap) begin ew = cur_word(); slot = 0; end
         else slot = (slot + 1) % 7;
         on = primed_m && power_on && !lost_m;
         for (int k = 0; k < 3; k++) ed[k] = on ? ew[7*k + 6 - slot] : 1'b0;
         ec = on ? CLK_PAT[6 - slot] : 1'b0;
         report(tag, ed, ec);
         pc_prev = pix_clk;
      end
      if (!stall) begin
         ph = (ph + 1) % 7;
         pix_clk = (ph < 4);
      end
   endtask

   initial begin
      put(21'h0);
      repeat (6) tick("R1 in reset");
      rst_n = 1'b1;
      put(21'h1AB_CDE);
      repeat (5) tick("R1 before first capture");

      // walking one through every word bit
      for (int b = 0; b < 21; b++) begin
         put(21'h1 << b);
         repeat (7) tick("R3 walking bit");
      end
      put(21'h1F_FFFF); repeat (7) tick("R3 all ones");
      put(21'h0);       repeat (7) tick("R3 all zeros");
      put(21'h15_5555); repeat (7) tick("R4 alternating");
      put(21'h0A_AAAA); repeat (7) tick("R4 alternating inverse");
      for (int i = 0; i < 64; i++) begin
         put(next_rand());
         repeat (7) tick("R3 random word");
      end
      // input changes on every bit clock: only the capture-edge value counts
      for (int i = 0; i < 140; i++) begin
         put(next_rand());
         tick("R2 per-bit input churn");
      end

      // stall the pixel clock high and low: repeat, then loss
      for (int lvl = 0; lvl < 2; lvl++) begin
         put(next_rand());
         while (pix_clk != lvl[0]) tick("R5 align stall");
         stall = 1;
         repeat (16) tick("R5 recirculate");
         repeat (30) tick("R6 lost clock");
         stall = 0;
         repeat (28) tick("R7 recovery");
      end

      // power-down released at each pixel phase
      for (int rel = 0; rel < 7; rel++) begin
         put(next_rand());
         repeat (5) tick("R5 pre power-down");
         power_on = 1'b0;
         repeat (20) tick("R8 powered down");
         while (ph != rel) tick("R8 powered down");
         power_on = 1'b1;
         put(next_rand());
         repeat (21) tick("R9 power release");
      end
      put(next_rand());
      repeat (14) tick("R3 final");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule